// File: doc/BRIEF.md
# Test-Port Instruction Register and Decoder

This block holds the 3-bit instruction of a memory device's boundary-scan test port and decodes it into the controls the rest of the test logic needs. An external TAP state machine supplies TCK and one strobe per relevant state: test-logic-reset, capture-IR, shift-IR, update-IR, capture-DR and shift-DR. Each strobe is high while the controller sits in that state, and the action happens on the rising TCK edge. Instructions are shifted in serially from TDI, LSB first. The old shift-stage contents leave on TDO at the same time. A new code becomes active only on update-IR.

The active code selects one of three data paths between TDI and TDO. These are the external boundary chain (its serial return enters on `bsr_si`), a 32-bit identification register, and a 1-bit bypass register. The code can also enable boundary drive onto the data pads, or force all data and clock output drivers to high impedance. TDO and its output enable are re-timed on the falling edge of TCK. Identification is the default instruction after power-up and after test-logic-reset.

Top module: `tap_ir_decode`

## Requirements
- R1: Power-up (`por_n` low) and a rising edge with `st_tlr` high both make the active code 001 (identification). `st_tlr` wins over `st_upd_ir` when both are high in the same cycle.
- R2: A rising edge with `st_cap_ir` high loads 001 into the shift stage, so the first three bits shifted out are 1, 0, 0.
- R3: While `st_shift_ir` is high, each rising edge moves TDI into the shift stage MSB. The LSB is presented on TDO, so a bit shifted in appears on TDO three shifts later.
- R4: `ir_code` changes only on a rising edge with `st_update_ir` or `st_tlr` high. Update loads the shift-stage contents.
- R5: Code 000 selects the boundary chain and asserts `bsr_drive`. It does not assert `pads_hiz`.
- R6: Code 010 selects the boundary chain and asserts `pads_hiz`. Code 100 selects the boundary chain and asserts neither `pads_hiz` nor `bsr_drive`.
- R7: Code 001 selects the identification register. Capture-DR loads ID_VALUE (LSB is 1), and shift-DR sends it out LSB first, followed by the TDI bits.
- R8: Codes 011, 101, 110 and 111 select the bypass register. It captures 0 and delays TDI by one shift.
- R9: TDO changes only on falling TCK edges. `tdo_oe` is high only in the shift-IR and shift-DR states. While the boundary chain is selected in shift-DR, TDO carries `bsr_si`.
- R10: Exactly one of `sel_bsr`, `sel_id` and `sel_byp` is high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-up reset, active low |
| tdi | input | 1 | Serial test data in |
| st_tlr | input | 1 | TAP is in test-logic-reset |
| st_cap_ir | input | 1 | TAP is in capture-IR |
| st_shift_ir | input | 1 | TAP is in shift-IR |
| st_upd_ir | input | 1 | TAP is in update-IR |
| st_cap_dr | input | 1 | TAP is in capture-DR |
| st_shift_dr | input | 1 | TAP is in shift-DR |
| bsr_si | input | 1 | Serial return of the boundary chain |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| tdo_oe | output | 1 | TDO output enable |
| ir_code | output | 3 | Active instruction code |
| sel_bsr | output | 1 | Boundary chain selected |
| sel_id | output | 1 | Identification register selected |
| sel_byp | output | 1 | Bypass register selected |
| bsr_drive | output | 1 | Drive boundary data onto data pads |
| pads_hiz | output | 1 | Force data and clock outputs to high impedance |

## Verification
Test-logic-reset and update-IR can coincide when the state strobes glitch or the controller resets asynchronously relative to the shift sequence. In that case the reset must win. The bench shifts 111 into the shift stage and then raises `st_tlr` and `st_upd_ir` together. The coincidence passes only if the next active code is 001 with the identification register selected, and not bypass. Random codes mixed with the fixed ones also check that shifting a new code leaves the active decode untouched until the update cycle.

// File: rtl/tap_ir_decode.sv
module tap_ir_decode #(
  parameter int ID_W = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h4D2C_19A3
) (
  input  logic       tck,
  input  logic       por_n,
  input  logic       tdi,
  input  logic       st_tlr,
  input  logic       st_cap_ir,
  input  logic       st_shift_ir,
  input  logic       st_upd_ir,
  input  logic       st_cap_dr,
  input  logic       st_shift_dr,
  input  logic       bsr_si,
  output logic       tdo,
  output logic       tdo_oe,
  output logic [2:0] ir_code,
  output logic       sel_bsr,
  output logic       sel_id,
  output logic       sel_byp,
  output logic       bsr_drive,
  output logic       pads_hiz
);

  localparam logic [2:0] OP_EXTEST = 3'b000;
  localparam logic [2:0] OP_IDCODE = 3'b001;
  localparam logic [2:0] OP_SAMPZ  = 3'b010;
  localparam logic [2:0] OP_SAMPLE = 3'b100;
  localparam logic [2:0] IR_CAPT   = 3'b001;

  logic [2:0]      ir_sr;
  logic            byp_q;
  logic [ID_W-1:0] id_sr;
  logic            tdo_mux;

  always_ff @(posedge tck or negedge por_n)
    if (!por_n)                      ir_sr <= IR_CAPT;
    else if (st_tlr || st_cap_ir)    ir_sr <= IR_CAPT;
    else if (st_shift_ir)            ir_sr <= {tdi, ir_sr[2:1]};

  always_ff @(posedge tck or negedge por_n)
    if (!por_n)          ir_code <= OP_IDCODE;
    else if (st_tlr)     ir_code <= OP_IDCODE;
    else if (st_upd_ir)  ir_code <= ir_sr;

  always_comb begin
    {sel_bsr, sel_id, sel_byp, bsr_drive, pads_hiz} = 5'b00100;
    case (ir_code)
      OP_EXTEST: {sel_bsr, sel_id, sel_byp, bsr_drive, pads_hiz} = 5'b10010;
      OP_IDCODE: {sel_bsr, sel_id, sel_byp, bsr_drive, pads_hiz} = 5'b01000;
      OP_SAMPZ:  {sel_bsr, sel_id, sel_byp, bsr_drive, pads_hiz} = 5'b10001;
      OP_SAMPLE: {sel_bsr, sel_id, sel_byp, bsr_drive, pads_hiz} = 5'b10000;
      default:   {sel_bsr, sel_id, sel_byp, bsr_drive, pads_hiz} = 5'b00100;
    endcase
  end

  always_ff @(posedge tck or negedge por_n)
    if (!por_n)                        byp_q <= 1'b0;
    else if (st_cap_dr && sel_byp)     byp_q <= 1'b0;
    else if (st_shift_dr && sel_byp)   byp_q <= tdi;

  always_ff @(posedge tck or negedge por_n)
    if (!por_n)                        id_sr <= ID_VALUE;
    else if (st_cap_dr && sel_id)      id_sr <= ID_VALUE;
    else if (st_shift_dr && sel_id)    id_sr <= {tdi, id_sr[ID_W-1:1]};

  assign tdo_mux = st_shift_ir ? ir_sr[0] :
                   sel_id      ? id_sr[0] :
                   sel_bsr     ? bsr_si   : byp_q;

  always_ff @(negedge tck or negedge por_n)
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_mux;
      tdo_oe <= st_shift_ir || st_shift_dr;
    end

endmodule

// File: rtl/tap_ir_decode_chk.sv
module tap_ir_decode_chk (
  input logic       tck,
  input logic       por_n,
  input logic       tdi,
  input logic       st_tlr,
  input logic       st_cap_ir,
  input logic       st_shift_ir,
  input logic       st_upd_ir,
  input logic       st_cap_dr,
  input logic [2:0] ir_sr,
  input logic [2:0] ir_code,
  input logic       sel_bsr,
  input logic       sel_id,
  input logic       sel_byp,
  input logic       bsr_drive,
  input logic       pads_hiz,
  input logic       byp_q
);

  AST_TLR_IDCODE: assert property (@(posedge tck) disable iff (!por_n)
    st_tlr |=> (ir_code == 3'b001) && sel_id); // R1

  AST_CAP_IR: assert property (@(posedge tck) disable iff (!por_n)
    st_cap_ir && !st_tlr |=> ir_sr == 3'b001); // R2

  AST_SHIFT_IR: assert property (@(posedge tck) disable iff (!por_n)
    st_shift_ir && !st_tlr && !st_cap_ir |=> ir_sr[2] == $past(tdi)); // R3

  AST_IR_HOLD: assert property (@(posedge tck) disable iff (!por_n)
    !st_upd_ir && !st_tlr |=> $stable(ir_code)); // R4

  AST_UPD_LOAD: assert property (@(posedge tck) disable iff (!por_n)
    st_upd_ir && !st_tlr |=> ir_code == $past(ir_sr)); // R4

  AST_DRIVE_BSR: assert property (@(posedge tck) disable iff (!por_n)
    bsr_drive |-> sel_bsr && !pads_hiz); // R5

  AST_HIZ_BSR: assert property (@(posedge tck) disable iff (!por_n)
    pads_hiz |-> sel_bsr && !bsr_drive); // R6

  AST_BYP_CAP: assert property (@(posedge tck) disable iff (!por_n)
    st_cap_dr && sel_byp |=> !byp_q); // R8

  AST_ONE_SEL: assert property (@(posedge tck) disable iff (!por_n)
    $onehot({sel_bsr, sel_id, sel_byp})); // R10

endmodule

bind tap_ir_decode tap_ir_decode_chk u_chk (
  .tck(tck), .por_n(por_n), .tdi(tdi), .st_tlr(st_tlr),
  .st_cap_ir(st_cap_ir), .st_shift_ir(st_shift_ir), .st_upd_ir(st_upd_ir),
  .st_cap_dr(st_cap_dr), .ir_sr(ir_sr), .ir_code(ir_code),
  .sel_bsr(sel_bsr), .sel_id(sel_id), .sel_byp(sel_byp),
  .bsr_drive(bsr_drive), .pads_hiz(pads_hiz), .byp_q(byp_q)
);

// File: tb/tap_ir_decode_tb.sv
`timescale 1ns/1ps
module tap_ir_decode_tb;

  localparam logic [31:0] ID = 32'h4D2C_19A3;
  localparam logic [5:0] S_IDLE = 6'b000000, S_TLR = 6'b100000,
                         S_CIR  = 6'b010000, S_SIR = 6'b001000,
                         S_UIR  = 6'b000100, S_CDR = 6'b000010,
                         S_SDR  = 6'b000001;

  logic tck = 1'b0, por_n, tdi, bsr_si;
  logic st_tlr, st_cap_ir, st_shift_ir, st_upd_ir, st_cap_dr, st_shift_dr;
  logic tdo, tdo_oe, sel_bsr, sel_id, sel_byp, bsr_drive, pads_hiz;
  logic [2:0] ir_code;
  logic early, so, oe;
  int nrun = 0, nfail = 0;

  always #4 tck = ~tck;

  tap_ir_decode #(.ID_W(32), .ID_VALUE(ID)) u_dut (
    .tck(tck), .por_n(por_n), .tdi(tdi), .st_tlr(st_tlr),
    .st_cap_ir(st_cap_ir), .st_shift_ir(st_shift_ir), .st_upd_ir(st_upd_ir),
    .st_cap_dr(st_cap_dr), .st_shift_dr(st_shift_dr), .bsr_si(bsr_si),
    .tdo(tdo), .tdo_oe(tdo_oe), .ir_code(ir_code), .sel_bsr(sel_bsr),
    .sel_id(sel_id), .sel_byp(sel_byp), .bsr_drive(bsr_drive),
    .pads_hiz(pads_hiz)
  );

  function automatic logic [4:0] exp_dec(input logic [2:0] c);
    case (c)
      3'b000:  return 5'b10010;
      3'b001:  return 5'b01000;
      3'b010:  return 5'b10001;
      3'b100:  return 5'b10000;
      default: return 5'b00100;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nrun++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [5:0] s, input logic d, input logic b);
    {st_tlr, st_cap_ir, st_shift_ir, st_upd_ir, st_cap_dr, st_shift_dr} = s;
    tdi = d; bsr_si = b;
    early = tdo;
    #5;
    so = tdo; oe = tdo_oe;
    @(posedge tck); #1;
  endtask

  task automatic check_dec(input string req);
    check(req, {sel_bsr, sel_id, sel_byp, bsr_drive, pads_hiz}, exp_dec(ir_code));
    check("R10 one select", 32'($countones({sel_bsr, sel_id, sel_byp})), 1);
  endtask

  task automatic scan_ir(input logic [2:0] code);
    logic [2:0] prev = ir_code;
    logic [2:0] junk = 3'($urandom);
    cyc(S_CIR, 1'b0, 1'b0);
    check("R9 oe low in capture-IR", oe, 0);
    for (int i = 0; i < 6; i++) begin
      cyc(S_SIR, (i < 3) ? junk[i] : code[i-3], 1'b0);
      if (i < 3) check("R2 captured pattern", so, (i == 0));
      else       check("R3 shift-through", so, junk[i-3]);
      check("R9 oe high in shift-IR", oe, 1);
    end
    check("R4 hold before update", ir_code, prev);
    cyc(S_UIR, 1'b0, 1'b0);
    check("R4 update loads code", ir_code, code);
    case (code)
      3'b000:  check_dec("R5 extest decode");
      3'b001:  check_dec("R7 id decode");
      3'b010, 3'b100: check_dec("R6 sample decode");
      default: check_dec("R8 bypass decode");
    endcase
  endtask

  task automatic scan_dr();
    logic [4:0] d = exp_dec(ir_code);
    logic [33:0] tin = {2'($urandom), 32'($urandom)};
    logic [33:0] bin = {2'($urandom), 32'($urandom)};
    logic prev_so = 1'b0;
    logic e;
    cyc(S_CDR, 1'b0, 1'b0);
    check("R9 oe low in capture-DR", oe, 0);
    for (int k = 0; k < 34; k++) begin
      cyc(S_SDR, tin[k], bin[k]);
      if (d[4]) begin
        e = bin[k];
        check("R9 boundary return on tdo", so, e);
      end else if (d[3]) begin
        e = (k < 32) ? ID[k] : tin[k-32];
        check("R7 id stream", so, e);
      end else begin
        e = (k == 0) ? 1'b0 : tin[k-1];
        check("R8 bypass stream", so, e);
      end
      if (k > 0) check("R9 tdo stable at rising edge", early, prev_so);
      prev_so = so;
    end
    cyc(S_IDLE, 1'b0, 1'b0);
    check("R9 oe low after shift", oe, 0);
  endtask

  initial begin
    #1_000_000;
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    por_n = 1'b0; tdi = 1'b0; bsr_si = 1'b0;
    {st_tlr, st_cap_ir, st_shift_ir, st_upd_ir, st_cap_dr, st_shift_dr} = S_IDLE;
    repeat (2) @(posedge tck);
    #1;
    check("R1 reset code", ir_code, 3'b001);
    check_dec("R1 reset decode");
    check("R9 reset oe", tdo_oe, 0);
    por_n = 1'b1;
    cyc(S_IDLE, 1'b0, 1'b0);
    scan_dr();
    for (int c = 0; c < 8; c++) begin
      scan_ir(3'(c));
      scan_dr();
    end
    scan_ir(3'b111);
    cyc(S_TLR, 1'b0, 1'b0);
    check("R1 tlr restores id", ir_code, 3'b001);
    cyc(S_CIR, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) cyc(S_SIR, 1'b1, 1'b0);
    cyc(S_TLR | S_UIR, 1'b0, 1'b0);
    check("R1 tlr beats update", ir_code, 3'b001);
    check("R1 id selected", sel_id, 1);
    scan_dr();
    for (int n = 0; n < 40; n++) begin
      scan_ir(3'($urandom));
      if ($urandom % 4 == 0) begin
        cyc(S_TLR, 1'b0, 1'b0);
        check("R1 random tlr", ir_code, 3'b001);
      end
      scan_dr();
    end
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

endmodule